// File: doc/BRIEF.md
# Posted-Write Clock-Crossing Register Bridge

This block connects a register command port running on a fast bus clock to a bank of timer registers clocked by a slower, unrelated timer clock. A few registers exist only on the bus side: an identity word, a general configuration word, the write-pending status word and the interface control word. These registers always answer one bus cycle after the command is taken. Writes to the timer-side registers cross the clock boundary through one toggle handshake per register. The handshake has a two-flop synchronizer in each direction and a holding register that stays frozen while its request is in flight.

A mode bit in the interface control word selects how timer-side writes are acknowledged. In posted mode the bus command is accepted at once and the write completes later, and a per-register pending bit tracks it until it lands. In non-posted mode the accept is withheld until the timer side has taken the value. The mode bit is loaded from a static strap input at reset, and software can rewrite it afterwards. If a register is written again while its earlier write is still waiting to cross, the waiting value is replaced without notice. A separate handshake loop samples the timer's free-running counter into a bus-side capture register, so a counter read costs no synchronization delay.

The address map uses word addresses. Address 0 holds the identity word, 1 the configuration word, 2 the pending status, 3 the interface control, 4 the counter capture, and 8+i timer register i.

Top module: `pwb_bridge`

## Requirements
- R1: A command to address 0, 1, 2, 3 or 4, or to an unmapped address, is accepted exactly one bus cycle after it is taken, whatever the mode. Unmapped reads return zero, writes to addresses 0, 2 and 4 are ignored, and address 1 reads back what was written.
- R2: Bit 0 of the interface control word (address 3) is the posted-mode bit. At reset it takes the value of `posted_strap`, and a bus write can change it later.
- R3: In posted mode a write to timer register i (address 8+i) is accepted one bus cycle after it is taken. The value appears on the timer-side output within four timer clocks of the accept.
- R4: Bit i of the pending status word (address 2) is set from the accept of a posted write to timer register i until that write has landed. It clears within four timer clocks plus six bus clocks of the accept.
- R5: Several writes to one timer register may arrive while an earlier write is still in flight. The in-flight value still lands, each newer write replaces the one waiting behind it, and only the last one is delivered after it. A replaced value never appears on the timer side.
- R6: In non-posted mode a write to a timer register is not accepted until the timer-side output holds the new value and all pending bits are clear.
- R7: A read of address 4 is accepted in one bus cycle. It returns a timer counter value that is never ahead of the live counter and at most eight timer counts behind it, and later reads return larger samples.
- R8: A read of timer register i returns the last value written to it from the bus, in one bus cycle.
- R9: After reset the accept output is low, the timer register outputs and write pulses are zero, and the configuration and pending status words read zero.
- R10: `cmd_accept` is a one-cycle pulse. Read data is valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain synchronous reset, active low |
| posted_strap | input | 1 | Static reset value of the posted-mode bit |
| cmd_valid | input | 1 | Command request, held until accepted |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DW | Write data |
| cmd_accept | output | 1 | One-cycle command accept |
| rsp_rdata | output | DW | Read data, valid with accept |
| tclk | input | 1 | Timer functional clock |
| trst_n | input | 1 | Timer-domain synchronous reset, active low |
| t_count | input | DW | Free-running timer counter (timer domain) |
| t_regs | output | NREG*DW | Timer register values, register i at bits i*DW |
| t_wr_pulse | output | NREG | One-tclk pulse when register i is updated |

## Verification
On every bus cycle the assertions check the accept timing. Bus-only commands and posted timer writes get a single-cycle accept, and that accept is always a one-cycle pulse. A non-posted write is held while anything is pending and released as soon as nothing is. Each channel write must raise a pending bit, and at most one channel may be written at a time. The delivered timer-side values can only be shown by the bench's scenarios, since they cross an asynchronous boundary. These scenarios cover the landing and pending-clear latency bounds, the replacement of a waiting write so that only the last value is delivered, the freshness of the counter capture, and the strap value loaded at reset.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  localparam int unsigned ADR_ID    = 0;
  localparam int unsigned ADR_CFG   = 1;
  localparam int unsigned ADR_WPS   = 2;
  localparam int unsigned ADR_IFC   = 3;
  localparam int unsigned ADR_CNT   = 4;
  localparam int unsigned TMR_BASE  = 8;

  typedef enum logic {CTL_IDLE = 1'b0, CTL_NP_WAIT = 1'b1} ctl_state_e;

  typedef enum logic [2:0] {
    RK_ID, RK_CFG, RK_WPS, RK_IFC, RK_CNT, RK_TMR, RK_NONE
  } reg_kind_e;

  function automatic reg_kind_e decode_kind(input int unsigned a, input int unsigned nreg);
    if (a == ADR_ID)  return RK_ID;
    if (a == ADR_CFG) return RK_CFG;
    if (a == ADR_WPS) return RK_WPS;
    if (a == ADR_IFC) return RK_IFC;
    if (a == ADR_CNT) return RK_CNT;
    if (a >= TMR_BASE && a < TMR_BASE + nreg) return RK_TMR;
    return RK_NONE;
  endfunction

  function automatic int unsigned tmr_index(input int unsigned a);
    return a - TMR_BASE;
  endfunction

endpackage

// File: rtl/pwb_sync2.sv
module pwb_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pwb_post_chan.sv
module pwb_post_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          pend,
  output logic          launch,
  input  logic          tclk,
  input  logic          trst_n,
  output logic [DW-1:0] t_value,
  output logic          t_pulse
);
  logic          req_tgl, ack_s, queued, inflight;
  logic [DW-1:0] hold_q, next_q;
  logic          ack_tgl, req_s, req_d, t_edge;

  assign inflight = req_tgl ^ ack_s;
  assign launch   = !inflight && (wr_en || queued);
  assign pend     = inflight || queued;

  // Bus side: one value in flight, one waiting; a newer write replaces the waiting one.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_tgl <= 1'b0;
      queued  <= 1'b0;
      hold_q  <= '0;
      next_q  <= '0;
    end else if (launch) begin
      req_tgl <= ~req_tgl;
      hold_q  <= wr_en ? wr_data : next_q;
      queued  <= 1'b0;
    end else if (wr_en) begin
      queued  <= 1'b1;
      next_q  <= wr_data;
    end
  end

  pwb_sync2 #(.W(1)) u_ack_sync (.clk(clk),  .rst_n(rst_n),  .d(ack_tgl), .q(ack_s));
  pwb_sync2 #(.W(1)) u_req_sync (.clk(tclk), .rst_n(trst_n), .d(req_tgl), .q(req_s));

  assign t_edge = req_s ^ req_d;

  // Timer side: hold_q is frozen while the request toggle is travelling.
  always_ff @(posedge tclk) begin
    if (!trst_n) begin
      req_d   <= 1'b0;
      ack_tgl <= 1'b0;
      t_value <= '0;
      t_pulse <= 1'b0;
    end else begin
      req_d   <= req_s;
      t_pulse <= t_edge;
      if (t_edge) begin
        t_value <= hold_q;
        ack_tgl <= req_s;
      end
    end
  end
endmodule

// File: rtl/pwb_cnt_cap.sv
module pwb_cnt_cap #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] capture,
  input  logic          tclk,
  input  logic          trst_n,
  input  logic [DW-1:0] t_count
);
  logic          cap_req, ack_s, ack_tgl, req_s;
  logic [DW-1:0] t_snap;
  logic          idle;

  assign idle = (cap_req == ack_s);

  // Bus side: each returned snapshot is taken and the next one requested at once.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_req <= 1'b0;
      capture <= '0;
    end else if (idle) begin
      capture <= t_snap;
      cap_req <= ~cap_req;
    end
  end

  pwb_sync2 #(.W(1)) u_ack_sync (.clk(clk),  .rst_n(rst_n),  .d(ack_tgl), .q(ack_s));
  pwb_sync2 #(.W(1)) u_req_sync (.clk(tclk), .rst_n(trst_n), .d(cap_req), .q(req_s));

  always_ff @(posedge tclk) begin
    if (!trst_n) begin
      ack_tgl <= 1'b0;
      t_snap  <= '0;
    end else if (req_s != ack_tgl) begin
      t_snap  <= t_count;
      ack_tgl <= req_s;
    end
  end
endmodule

// File: rtl/pwb_bridge.sv
module pwb_bridge
  import pwb_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter int          DW       = 32,
  parameter int          NREG     = 3,
  parameter logic [31:0] ID_VALUE = 32'h0051_7A01
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 posted_strap,
  input  logic                 cmd_valid,
  input  logic                 cmd_write,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic [DW-1:0]        cmd_wdata,
  output logic                 cmd_accept,
  output logic [DW-1:0]        rsp_rdata,
  input  logic                 tclk,
  input  logic                 trst_n,
  input  logic [DW-1:0]        t_count,
  output logic [NREG*DW-1:0]   t_regs,
  output logic [NREG-1:0]      t_wr_pulse
);
  localparam int unsigned MAP_TOP = TMR_BASE + NREG;

  ctl_state_e     state;
  reg_kind_e      kind;
  int unsigned    tidx;
  logic           mode_posted;
  logic [DW-1:0]  cfg_q, capture, rd_val;
  logic [DW-1:0]  shadow [NREG];
  logic [NREG-1:0] chan_wr, pend, chan_launch;

  // Named events for the checker
  logic cmd_take, np_start, take_fast, take_tmr_posted, np_wait, pend_any;

  assign kind            = decode_kind(32'(cmd_addr), NREG);
  assign tidx            = tmr_index(32'(cmd_addr));
  assign cmd_take        = cmd_valid && !cmd_accept && (state == CTL_IDLE);
  assign np_start        = cmd_take && cmd_write && (kind == RK_TMR) && !mode_posted;
  assign take_fast       = cmd_take && !np_start;
  assign take_tmr_posted = cmd_take && cmd_write && (kind == RK_TMR) && mode_posted;
  assign np_wait         = (state == CTL_NP_WAIT);
  assign pend_any        = |pend;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_chan
      assign chan_wr[i] = cmd_take && cmd_write && (kind == RK_TMR) && (tidx == i);

      pwb_post_chan #(.DW(DW)) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (chan_wr[i]),
        .wr_data (cmd_wdata),
        .pend    (pend[i]),
        .launch  (chan_launch[i]),
        .tclk    (tclk),
        .trst_n  (trst_n),
        .t_value (t_regs[i*DW +: DW]),
        .t_pulse (t_wr_pulse[i])
      );

      always_ff @(posedge clk) begin
        if (!rst_n)          shadow[i] <= '0;
        else if (chan_wr[i]) shadow[i] <= cmd_wdata;
      end
    end
  endgenerate

  pwb_cnt_cap #(.DW(DW)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .tclk    (tclk),
    .trst_n  (trst_n),
    .t_count (t_count)
  );

  always_comb begin
    rd_val = '0;
    unique case (kind)
      RK_ID:   rd_val = DW'(ID_VALUE);
      RK_CFG:  rd_val = cfg_q;
      RK_WPS:  rd_val[NREG-1:0] = pend;
      RK_IFC:  rd_val[0] = mode_posted;
      RK_CNT:  rd_val = capture;
      RK_TMR:  for (int i = 0; i < NREG; i++) if (tidx == i) rd_val = shadow[i];
      default: rd_val = '0;
    endcase
    if (32'(cmd_addr) >= MAP_TOP) rd_val = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= CTL_IDLE;
      cmd_accept  <= 1'b0;
      rsp_rdata   <= '0;
      mode_posted <= posted_strap;
      cfg_q       <= '0;
    end else begin
      cmd_accept <= 1'b0;
      unique case (state)
        CTL_IDLE: begin
          if (np_start) begin
            state <= CTL_NP_WAIT;
          end else if (cmd_take) begin
            cmd_accept <= 1'b1;
            rsp_rdata  <= cmd_write ? '0 : rd_val;
            if (cmd_write && kind == RK_CFG) cfg_q       <= cmd_wdata;
            if (cmd_write && kind == RK_IFC) mode_posted <= cmd_wdata[0];
          end
        end
        CTL_NP_WAIT: begin
          if (!pend_any) begin
            cmd_accept <= 1'b1;
            rsp_rdata  <= '0;
            state      <= CTL_IDLE;
          end
        end
        default: state <= CTL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwb_bridge_chk.sv
module pwb_bridge_chk #(
  parameter int NREG = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_accept,
  input logic            take_fast,
  input logic            take_tmr_posted,
  input logic            np_wait,
  input logic            pend_any,
  input logic [NREG-1:0] chan_wr
);
  AST_ACCEPT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> !cmd_accept); // R10
  AST_FAST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    take_fast |=> cmd_accept); // R1
  AST_POSTED_ACK_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    take_tmr_posted |=> (cmd_accept && pend_any)); // R3
  AST_NP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (np_wait && pend_any) |=> !cmd_accept); // R6
  AST_NP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (np_wait && !pend_any) |=> cmd_accept); // R6
  AST_PEND_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_wr) |=> pend_any); // R4
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_wr)); // R5
endmodule

bind pwb_bridge pwb_bridge_chk #(.NREG(NREG)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cmd_accept      (cmd_accept),
  .take_fast       (take_fast),
  .take_tmr_posted (take_tmr_posted),
  .np_wait         (np_wait),
  .pend_any        (pend_any),
  .chan_wr         (chan_wr)
);

// File: tb/tb_pwb_bridge.sv
module tb_pwb_bridge;
  localparam int DW = 32;
  localparam int NREG = 3;
  localparam int AW = 4;
  localparam logic [31:0] IDV = 32'h0051_7A01;
  localparam int TCLK_NS = 40;
  localparam int BCLK_NS = 8;

  logic clk = 0, tclk = 0;
  logic rst_n = 0, trst_n = 0, posted_strap = 1;
  logic cmd_valid = 0, cmd_write = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_accept;
  logic [DW-1:0] rsp_rdata, t_count;
  logic [NREG*DW-1:0] t_regs;
  logic [NREG-1:0] t_wr_pulse;

  always #4 clk = ~clk;
  always #20 tclk = ~tclk;

  pwb_bridge #(.ADDR_W(AW), .DW(DW), .NREG(NREG), .ID_VALUE(IDV)) dut (.*);

  always @(posedge tclk) begin
    if (!trst_n) t_count <= '0;
    else         t_count <= t_count + 1;
  end

  int pulses [NREG];
  logic [DW-1:0] forbid_val;
  logic forbid_seen;
  initial begin
    for (int i = 0; i < NREG; i++) pulses[i] = 0;
    forbid_val = '0; forbid_seen = 0;
  end
  always @(posedge tclk) begin
    for (int i = 0; i < NREG; i++) if (t_wr_pulse[i]) pulses[i] = pulses[i] + 1;
    if (t_wr_pulse[1] && t_regs[1*DW +: DW] == forbid_val) forbid_seen = 1;
  end

  int n_checks = 0, n_fail = 0;
  task automatic chk(input logic ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int cyc);
    @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_addr = a; cmd_wdata = d; cyc = 0;
    do begin
      @(posedge clk); cyc++; @(negedge clk);
    end while (!cmd_accept && cyc < 1000);
    rd = rsp_rdata;
    cmd_valid = 0;
  endtask

  task automatic do_reset(input logic strap);
    posted_strap = strap;
    rst_n = 0; trst_n = 0;
    repeat (4) @(posedge tclk);
    @(negedge clk); rst_n = 1; trst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [DW-1:0] expv;
  } vec_t;

  // Bus-only registers and unmapped space: all answer in one cycle (R1)
  localparam vec_t VECS [10] = '{
    '{1'b1, 4'd1,  32'hAAAA_5555, 32'h0},
    '{1'b0, 4'd1,  32'h0,         32'hAAAA_5555},
    '{1'b0, 4'd0,  32'h0,         IDV},
    '{1'b1, 4'd0,  32'hFFFF_FFFF, 32'h0},
    '{1'b0, 4'd0,  32'h0,         IDV},
    '{1'b0, 4'd5,  32'h0,         32'h0},
    '{1'b0, 4'd15, 32'h0,         32'h0},
    '{1'b1, 4'd2,  32'hFFFF_FFFF, 32'h0},
    '{1'b0, 4'd2,  32'h0,         32'h0},
    '{1'b1, 4'd1,  32'h0000_0000, 32'h0}
  };

  logic done = 0;
  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd, c1, c2;
    int cyc, p0;
    realtime t0, el;

    do_reset(1'b1);
    // R9 reset state
    chk(cmd_accept == 0, "R9 accept low", {31'b0, cmd_accept}, 0);
    chk(t_regs == '0, "R9 timer regs zero", t_regs[DW-1:0], 0);
    chk(t_wr_pulse == '0, "R9 pulses zero", {29'b0, t_wr_pulse}, 0);
    bus_op(0, 4'd2, 0, rd, cyc); chk(rd == 0, "R9 wps zero", rd, 0);
    bus_op(0, 4'd1, 0, rd, cyc); chk(rd == 0, "R9 cfg zero", rd, 0);
    // R2 strap = 1
    bus_op(0, 4'd3, 0, rd, cyc); chk(rd == 1, "R2 strap1", rd, 1);

    // R1 table walk
    foreach (VECS[k]) begin
      bus_op(VECS[k].wr, VECS[k].addr, VECS[k].data, rd, cyc);
      chk(cyc == 1, "R1 one-cycle accept", cyc, 1);
      if (!VECS[k].wr) chk(rd == VECS[k].expv, "R1 read value", rd, VECS[k].expv);
    end

    // R3/R4 posted write with latency bounds
    bus_op(1, 4'd8, 32'hCAFE_0001, rd, cyc);
    t0 = $realtime;
    chk(cyc == 1, "R3 posted accept one cycle", cyc, 1);
    bus_op(0, 4'd2, 0, rd, cyc);
    chk(rd[0] == 1, "R4 pending set", rd, 1);
    while (t_regs[DW-1:0] != 32'hCAFE_0001 && ($realtime - t0) < 1000) #1;
    el = $realtime - t0;
    chk(el <= 4*TCLK_NS, "R3 landing bound", int'(el), 4*TCLK_NS);
    chk(t_regs[DW-1:0] == 32'hCAFE_0001, "R3 landed value", t_regs[DW-1:0], 32'hCAFE_0001);
    do bus_op(0, 4'd2, 0, rd, cyc); while (rd[0] && ($realtime - t0) < 1000);
    el = $realtime - t0;
    chk(el <= 4*TCLK_NS + 6*BCLK_NS, "R4 pending clear bound", int'(el), 4*TCLK_NS + 6*BCLK_NS);

    // R8 shadow read
    bus_op(1, 4'd10, 32'h1357_9BDF, rd, cyc);
    bus_op(0, 4'd10, 0, rd, cyc);
    chk(rd == 32'h1357_9BDF && cyc == 1, "R8 shadow read", rd, 32'h1357_9BDF);

    // R5 back-to-back writes: middle value replaced
    repeat (20) @(negedge clk);
    p0 = pulses[1];
    forbid_val = 32'hBBBB_0002; forbid_seen = 0;
    bus_op(1, 4'd9, 32'hAAAA_0001, rd, cyc);
    bus_op(1, 4'd9, 32'hBBBB_0002, rd, cyc);
    bus_op(1, 4'd9, 32'hCCCC_0003, rd, cyc);
    #600;
    chk(t_regs[DW +: DW] == 32'hCCCC_0003, "R5 last value lands", t_regs[DW +: DW], 32'hCCCC_0003);
    chk(pulses[1] - p0 == 2, "R5 two deliveries", pulses[1] - p0, 2);
    chk(!forbid_seen, "R5 replaced value never delivered", {31'b0, forbid_seen}, 0);
    bus_op(0, 4'd2, 0, rd, cyc); chk(rd == 0, "R5 pending clear", rd, 0);

    // R7 counter capture
    bus_op(0, 4'd4, 0, c1, cyc);
    chk(cyc == 1, "R7 capture one cycle", cyc, 1);
    chk(c1 <= t_count && (t_count - c1) <= 8, "R7 capture freshness", c1, t_count);
    #400;
    bus_op(0, 4'd4, 0, c2, cyc);
    chk(c2 > c1, "R7 capture advances", c2, c1);

    // R2 software override, R6 non-posted
    bus_op(1, 4'd3, 0, rd, cyc);
    bus_op(0, 4'd3, 0, rd, cyc); chk(rd == 0, "R2 software override", rd, 0);
    bus_op(1, 4'd8, 32'h0000_1234, rd, cyc);
    chk(cyc >= 5, "R6 accept withheld", cyc, 5);
    chk(t_regs[DW-1:0] == 32'h0000_1234, "R6 landed at accept", t_regs[DW-1:0], 32'h1234);
    bus_op(0, 4'd2, 0, rd, cyc); chk(rd == 0, "R6 nothing pending", rd, 0);
    bus_op(0, 4'd1, 0, rd, cyc); chk(cyc == 1, "R1 bus reg in non-posted mode", cyc, 1);

    // R2 strap = 0 at reset
    do_reset(1'b0);
    bus_op(0, 4'd3, 0, rd, cyc); chk(rd == 0, "R2 strap0", rd, 0);
    chk(t_regs == '0, "R9 regs cleared again", t_regs[DW-1:0], 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule